// File: doc/BRIEF.md
# Card Sector Read Sequencer

This block is a bus master that fetches a run of 512-byte sectors from a flash-card controller. The controller is reached through a 16-bit register window addressed by byte offset. A requester hands over a 28-bit starting logical block address and a sector count through a valid/ready handshake. The sequencer then takes the controller's ownership lock, waits until the card accepts commands, and issues read commands for pieces of at most 256 sectors. It then drains the controller's data buffer and streams the data out one byte at a time under valid/ready flow control.

Each request ends with a single-cycle `done` pulse that carries an error code. Any exit that happens after the lock was won gives the lock back first. A programmable cycle count sets the pause between status polls. Parameters set the poll limits, the number of buffer loads per sector and whether a configuration-controller reset is held during each piece.

Top module: `cfSectorReader`

## Requirements
- R1: Out of reset `reqReady` is high and `busReq`, `outValid` and `done` are low. A request with a sector count of 0 produces `done` in the cycle after the handshake, with `errCode` 0 and no bus request.
- R2: A non-empty request starts with a read of offset 0x18 and then a write of that same value with bit 1 set. After that, offset 0x04 is polled until its bit 1 (lock granted) reads 1.
- R3: If LOCK_POLLS status reads all show the lock not granted, the request ends without a release write. The code is 1 when status bit 4 (card present) was clear on the last read, and 2 when it was set.
- R4: Once the lock is held, status is polled for bit 8 (command ready). Bit 4 clear ends the request with code 1. READY_POLLS reads without bit 8 end it with code 3. In both cases the lock is released first.
- R5: Each piece writes its address as two words: bits 15:0 to offset 0x10, and bits 27:16 to offset 0x12 in bits 11:0 with bits 15:12 zero.
- R6: Each piece is min(remaining, 256) sectors. The command word written to offset 0x14 is 0x0300 OR'd with the piece size modulo 256, so a 256-sector piece is written as 0x0300.
- R7: With CFG_RESET set, bit 7 of offset 0x18 is set by read-modify-write before the piece's first data read. It is cleared by read-modify-write after the piece's last data read. Other bits are kept.
- R8: A piece takes size × READS_PER_SECTOR buffer loads. Each load waits for status bit 5 (buffer ready) and then reads offset 0x40 sixteen times.
- R9: Each data word is sent low byte first, then high byte. While `outValid` is high and `outReady` is low, `outValid` and `outByte` hold.
- R10: After each piece, the address advances by the piece size. The remaining count drops by the same amount.
- R11: A request that finishes normally clears bit 1 of offset 0x18 by read-modify-write and then pulses `done` for one cycle with `errCode` 0.
- R12: Only one bus access is in flight at a time. While `busReq` is high and `busAck` is low, `busReq`, `busWe` and `busAddr` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Sequencer idle and taking a request |
| reqLba | input | 28 | Starting logical block address |
| reqCount | input | COUNT_W | Number of sectors |
| waitCycles | input | WAIT_W | Pause in cycles between unsuccessful polls |
| busReq | output | 1 | Register access request |
| busWe | output | 1 | Access is a write |
| busAddr | output | 7 | Register byte offset |
| busWdata | output | 16 | Write data word |
| busAck | input | 1 | Access completes this cycle |
| busRdata | input | 16 | Read data word, valid with busAck |
| outValid | output | 1 | Stream byte valid |
| outByte | output | 8 | Stream byte |
| outReady | input | 1 | Downstream takes the byte |
| done | output | 1 | One-cycle end-of-request pulse |
| errCode | output | 2 | 0 ok, 1 no card, 2 locked out, 3 not ready; valid with done |

## Verification
The bench targets requests of 256 and 257 sectors and a start address just below a 64K boundary. A sequencer with wrong piece splitting would write a command word of 0x0301 or 0x0400 instead of 0x0300. A sequencer that carries the address wrongly would write a stale high word on the second piece. Both lock-timeout outcomes are driven, along with a ready timeout and a card pulled out mid-poll. These catch a swapped error code, an extra or missing status poll, and a lock that is left held or released when it was never taken. Random downstream stalls and buffer-ready delays expose bytes that are swapped, dropped or changed during a stall. A control value preset with an unrelated bit catches a read-modify-write that overwrites the whole register.

// File: rtl/cfrdPkg.sv
package cfrdPkg;

  localparam int ADDR_W = 7;
  localparam int LBA_W  = 28;
  localparam int WORDS_PER_LOAD = 16;
  localparam int PIECE_MAX = 256;
  localparam int PIECE_W = 9;

  localparam logic [ADDR_W-1:0] OFS_STATUS = 7'h04;
  localparam logic [ADDR_W-1:0] OFS_LBA_LO = 7'h10;
  localparam logic [ADDR_W-1:0] OFS_LBA_HI = 7'h12;
  localparam logic [ADDR_W-1:0] OFS_CMD    = 7'h14;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 7'h18;
  localparam logic [ADDR_W-1:0] OFS_DATA   = 7'h40;

  localparam logic [15:0] CMD_READ_CARD = 16'h0300;
  localparam logic [15:0] CTRL_LOCK_BIT = 16'h0002;
  localparam logic [15:0] CTRL_CFGRST_BIT = 16'h0080;

  localparam logic [1:0] ERR_NONE     = 2'd0;
  localparam logic [1:0] ERR_NO_CARD  = 2'd1;
  localparam logic [1:0] ERR_LOCKED   = 2'd2;
  localparam logic [1:0] ERR_NOTREADY = 2'd3;

  typedef enum logic [2:0] {
    W_LBA_LO, W_LBA_HI, W_CMD, W_LOCK_SET, W_LOCK_CLR, W_RST_SET, W_RST_CLR
  } wsel_e;

  typedef struct packed {
    logic cmdReady;
    logic bufReady;
    logic cardIn;
    logic lockGranted;
  } stat_t;

  typedef struct packed {
    logic  load;
    logic  advance;
    logic  capCtl;
    logic  capWord;
    logic  wordStep;
    logic  pollClr;
    logic  pollInc;
    logic  waitLoad;
    logic  waitDec;
    logic  hiSel;
    logic  outValid;
    wsel_e wsel;
  } strobe_t;

endpackage

// File: rtl/cfrdDatapath.sv
module cfrdDatapath
  import cfrdPkg::*;
#(
  parameter int COUNT_W = 16,
  parameter int READS_PER_SECTOR = 16,
  parameter int WAIT_W = 16,
  parameter int PW = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            st,
  input  logic [LBA_W-1:0]   reqLba,
  input  logic [COUNT_W-1:0] reqCount,
  input  logic [WAIT_W-1:0]  waitCycles,
  input  logic [15:0]        busRdata,
  output logic [15:0]        busWdata,
  output logic [7:0]         outByte,
  output logic               outValid,
  output logic               lastPiece,
  output logic               wordLast,
  output logic               loadLast,
  output logic [PW-1:0]      pollCnt,
  output logic               waitZero
);

  localparam int LOAD_W = $clog2(PIECE_MAX * READS_PER_SECTOR + 1);
  localparam int IDX_W  = $clog2(WORDS_PER_LOAD);

  logic [LBA_W-1:0]   lbaReg;
  logic [COUNT_W-1:0] remaining;
  logic [15:0]        ctlShadow;
  logic [15:0]        wordReg;
  logic [IDX_W-1:0]   wordIdx;
  logic [LOAD_W-1:0]  loadCnt;
  logic [WAIT_W-1:0]  waitCnt;
  logic [PIECE_W-1:0] pieceSize;
  logic [LOAD_W-1:0]  loadTarget;

  // piece size: remaining count clipped to the command field range
  always_comb begin
    if (remaining > COUNT_W'(PIECE_MAX)) pieceSize = PIECE_W'(PIECE_MAX);
    else                                 pieceSize = PIECE_W'(remaining);
  end

  assign lastPiece  = (remaining <= COUNT_W'(PIECE_MAX));
  assign loadTarget = LOAD_W'(pieceSize) * LOAD_W'(READS_PER_SECTOR);
  assign loadLast   = (loadCnt == loadTarget - LOAD_W'(1));
  assign wordLast   = (wordIdx == IDX_W'(WORDS_PER_LOAD - 1));
  assign waitZero   = (waitCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lbaReg    <= '0;
      remaining <= '0;
      loadCnt   <= '0;
      wordIdx   <= '0;
    end else if (st.load) begin
      lbaReg    <= reqLba;
      remaining <= reqCount;
      loadCnt   <= '0;
      wordIdx   <= '0;
    end else if (st.advance) begin
      lbaReg    <= lbaReg + LBA_W'(pieceSize);
      remaining <= remaining - COUNT_W'(pieceSize);
      loadCnt   <= '0;
    end else if (st.wordStep) begin
      wordIdx <= wordIdx + IDX_W'(1);
      if (wordLast) loadCnt <= loadCnt + LOAD_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlShadow <= '0;
      wordReg   <= '0;
    end else begin
      if (st.capCtl)  ctlShadow <= busRdata;
      if (st.capWord) wordReg   <= busRdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pollCnt <= '0;
      waitCnt <= '0;
    end else begin
      if (st.pollClr)      pollCnt <= '0;
      else if (st.pollInc) pollCnt <= pollCnt + PW'(1);
      if (st.waitLoad)     waitCnt <= waitCycles;
      else if (st.waitDec) waitCnt <= waitCnt - WAIT_W'(1);
    end
  end

  always_comb begin
    unique case (st.wsel)
      W_LBA_LO:   busWdata = lbaReg[15:0];
      W_LBA_HI:   busWdata = {4'b0000, lbaReg[LBA_W-1:16]};
      W_CMD:      busWdata = CMD_READ_CARD | {8'h00, pieceSize[7:0]};
      W_LOCK_SET: busWdata = ctlShadow | CTRL_LOCK_BIT;
      W_LOCK_CLR: busWdata = ctlShadow & ~CTRL_LOCK_BIT;
      W_RST_SET:  busWdata = ctlShadow | CTRL_CFGRST_BIT;
      W_RST_CLR:  busWdata = ctlShadow & ~CTRL_CFGRST_BIT;
      default:    busWdata = '0;
    endcase
  end

  assign outByte  = st.hiSel ? wordReg[15:8] : wordReg[7:0];
  assign outValid = st.outValid;

  // R10
  advance_nonempty_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.advance |-> (remaining != '0));

endmodule

// File: rtl/cfrdCtrl.sv
module cfrdCtrl
  import cfrdPkg::*;
#(
  parameter int LOCK_POLLS = 12,
  parameter int READY_POLLS = 2002,
  parameter int CFG_RESET = 1,
  parameter int PW = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqZero,
  output logic              reqReady,
  output logic              busReq,
  output logic              busWe,
  output logic [ADDR_W-1:0] busAddr,
  input  logic              busAck,
  input  stat_t             stat,
  input  logic              outReady,
  input  logic              lastPiece,
  input  logic              wordLast,
  input  logic              loadLast,
  input  logic [PW-1:0]     pollCnt,
  input  logic              waitZero,
  output strobe_t           st,
  output logic              done,
  output logic [1:0]        errCode
);

  typedef enum logic [4:0] {
    S_IDLE, S_LK_RD, S_LK_WR, S_LK_POLL, S_LK_WAIT,
    S_RDY_POLL, S_RDY_WAIT, S_LBA_LO, S_LBA_HI, S_CMD,
    S_RST_RD, S_RST_WR, S_BUF_POLL, S_BUF_WAIT, S_DRAIN_RD,
    S_EMIT_LO, S_EMIT_HI, S_UNRST_RD, S_UNRST_WR, S_ADV,
    S_REL_RD, S_REL_WR, S_DONE
  } state_e;

  state_e     state, nxt;
  logic [1:0] errReg, errNxt;
  logic       hasCfgReset;

  assign hasCfgReset = (CFG_RESET != 0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      errReg <= ERR_NONE;
    end else begin
      state  <= nxt;
      errReg <= errNxt;
    end
  end

  assign errCode = errReg;

  always_comb begin
    st       = '0;
    st.wsel  = W_LBA_LO;
    busReq   = 1'b0;
    busWe    = 1'b0;
    busAddr  = '0;
    reqReady = 1'b0;
    done     = 1'b0;
    nxt      = state;
    errNxt   = errReg;
    unique case (state)
      S_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          st.load = 1'b1;
          errNxt  = ERR_NONE;
          nxt     = reqZero ? S_DONE : S_LK_RD;
        end
      end
      S_LK_RD: begin
        busReq = 1'b1; busAddr = OFS_CTRL;
        if (busAck) begin st.capCtl = 1'b1; nxt = S_LK_WR; end
      end
      S_LK_WR: begin
        busReq = 1'b1; busWe = 1'b1; busAddr = OFS_CTRL; st.wsel = W_LOCK_SET;
        if (busAck) begin st.pollClr = 1'b1; nxt = S_LK_POLL; end
      end
      S_LK_POLL: begin
        busReq = 1'b1; busAddr = OFS_STATUS;
        if (busAck) begin
          if (stat.lockGranted) begin
            st.pollClr = 1'b1; nxt = S_RDY_POLL;
          end else if (pollCnt == PW'(LOCK_POLLS - 1)) begin
            errNxt = stat.cardIn ? ERR_LOCKED : ERR_NO_CARD;
            nxt    = S_DONE;
          end else begin
            st.pollInc = 1'b1; st.waitLoad = 1'b1; nxt = S_LK_WAIT;
          end
        end
      end
      S_LK_WAIT: begin
        if (waitZero) nxt = S_LK_POLL;
        else          st.waitDec = 1'b1;
      end
      S_RDY_POLL: begin
        busReq = 1'b1; busAddr = OFS_STATUS;
        if (busAck) begin
          if (!stat.cardIn) begin
            errNxt = ERR_NO_CARD; nxt = S_REL_RD;
          end else if (stat.cmdReady) begin
            nxt = S_LBA_LO;
          end else if (pollCnt == PW'(READY_POLLS - 1)) begin
            errNxt = ERR_NOTREADY; nxt = S_REL_RD;
          end else begin
            st.pollInc = 1'b1; st.waitLoad = 1'b1; nxt = S_RDY_WAIT;
          end
        end
      end
      S_RDY_WAIT: begin
        if (waitZero) nxt = S_RDY_POLL;
        else          st.waitDec = 1'b1;
      end
      S_LBA_LO: begin
        busReq = 1'b1; busWe = 1'b1; busAddr = OFS_LBA_LO; st.wsel = W_LBA_LO;
        if (busAck) nxt = S_LBA_HI;
      end
      S_LBA_HI: begin
        busReq = 1'b1; busWe = 1'b1; busAddr = OFS_LBA_HI; st.wsel = W_LBA_HI;
        if (busAck) nxt = S_CMD;
      end
      S_CMD: begin
        busReq = 1'b1; busWe = 1'b1; busAddr = OFS_CMD; st.wsel = W_CMD;
        if (busAck) nxt = hasCfgReset ? S_RST_RD : S_BUF_POLL;
      end
      S_RST_RD: begin
        busReq = 1'b1; busAddr = OFS_CTRL;
        if (busAck) begin st.capCtl = 1'b1; nxt = S_RST_WR; end
      end
      S_RST_WR: begin
        busReq = 1'b1; busWe = 1'b1; busAddr = OFS_CTRL; st.wsel = W_RST_SET;
        if (busAck) nxt = S_BUF_POLL;
      end
      S_BUF_POLL: begin
        busReq = 1'b1; busAddr = OFS_STATUS;
        if (busAck) begin
          if (stat.bufReady) nxt = S_DRAIN_RD;
          else begin st.waitLoad = 1'b1; nxt = S_BUF_WAIT; end
        end
      end
      S_BUF_WAIT: begin
        if (waitZero) nxt = S_BUF_POLL;
        else          st.waitDec = 1'b1;
      end
      S_DRAIN_RD: begin
        busReq = 1'b1; busAddr = OFS_DATA;
        if (busAck) begin st.capWord = 1'b1; nxt = S_EMIT_LO; end
      end
      S_EMIT_LO: begin
        st.outValid = 1'b1;
        if (outReady) nxt = S_EMIT_HI;
      end
      S_EMIT_HI: begin
        st.outValid = 1'b1; st.hiSel = 1'b1;
        if (outReady) begin
          st.wordStep = 1'b1;
          if (!wordLast)     nxt = S_DRAIN_RD;
          else if (!loadLast) nxt = S_BUF_POLL;
          else               nxt = hasCfgReset ? S_UNRST_RD : S_ADV;
        end
      end
      S_UNRST_RD: begin
        busReq = 1'b1; busAddr = OFS_CTRL;
        if (busAck) begin st.capCtl = 1'b1; nxt = S_UNRST_WR; end
      end
      S_UNRST_WR: begin
        busReq = 1'b1; busWe = 1'b1; busAddr = OFS_CTRL; st.wsel = W_RST_CLR;
        if (busAck) nxt = S_ADV;
      end
      S_ADV: begin
        st.advance = 1'b1;
        nxt = lastPiece ? S_REL_RD : S_LBA_LO;
      end
      S_REL_RD: begin
        busReq = 1'b1; busAddr = OFS_CTRL;
        if (busAck) begin st.capCtl = 1'b1; nxt = S_REL_WR; end
      end
      S_REL_WR: begin
        busReq = 1'b1; busWe = 1'b1; busAddr = OFS_CTRL; st.wsel = W_LOCK_CLR;
        if (busAck) nxt = S_DONE;
      end
      S_DONE: begin
        done = 1'b1;
        nxt  = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  // R12
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busAck) |=> (busReq && $stable(busAddr) && $stable(busWe)));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8
  stream_bus_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(st.outValid && busReq));

endmodule

// File: rtl/cfSectorReader.sv
module cfSectorReader
  import cfrdPkg::*;
#(
  parameter int COUNT_W = 16,
  parameter int LOCK_POLLS = 12,
  parameter int READY_POLLS = 2002,
  parameter int READS_PER_SECTOR = 16,
  parameter int CFG_RESET = 1,
  parameter int WAIT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [27:0]        reqLba,
  input  logic [COUNT_W-1:0] reqCount,
  input  logic [WAIT_W-1:0]  waitCycles,
  output logic               busReq,
  output logic               busWe,
  output logic [6:0]         busAddr,
  output logic [15:0]        busWdata,
  input  logic               busAck,
  input  logic [15:0]        busRdata,
  output logic               outValid,
  output logic [7:0]         outByte,
  input  logic               outReady,
  output logic               done,
  output logic [1:0]         errCode
);

  localparam int POLL_MAX = (LOCK_POLLS > READY_POLLS) ? LOCK_POLLS : READY_POLLS;
  localparam int PW = $clog2(POLL_MAX + 1);

  strobe_t       st;
  stat_t         stat;
  logic          lastPiece, wordLast, loadLast, waitZero;
  logic [PW-1:0] pollCnt;

  assign stat = '{cmdReady: busRdata[8], bufReady: busRdata[5],
                  cardIn: busRdata[4], lockGranted: busRdata[1]};

  cfrdCtrl #(
    .LOCK_POLLS(LOCK_POLLS), .READY_POLLS(READY_POLLS),
    .CFG_RESET(CFG_RESET), .PW(PW)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqZero(reqCount == '0),
    .reqReady(reqReady), .busReq(busReq), .busWe(busWe), .busAddr(busAddr),
    .busAck(busAck), .stat(stat), .outReady(outReady), .lastPiece(lastPiece),
    .wordLast(wordLast), .loadLast(loadLast), .pollCnt(pollCnt),
    .waitZero(waitZero), .st(st), .done(done), .errCode(errCode)
  );

  cfrdDatapath #(
    .COUNT_W(COUNT_W), .READS_PER_SECTOR(READS_PER_SECTOR),
    .WAIT_W(WAIT_W), .PW(PW)
  ) uData (
    .clk(clk), .rstN(rstN), .st(st), .reqLba(reqLba), .reqCount(reqCount),
    .waitCycles(waitCycles), .busRdata(busRdata), .busWdata(busWdata),
    .outByte(outByte), .outValid(outValid), .lastPiece(lastPiece),
    .wordLast(wordLast), .loadLast(loadLast), .pollCnt(pollCnt),
    .waitZero(waitZero)
  );

  // R9
  stream_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outByte)));

  // R1
  zero_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqCount == '0) |=> (done && errCode == 2'd0 && !busReq));

endmodule

// File: tb/sim_cfSectorReader.sv
module sim_cfSectorReader;

  localparam int LP = 4;
  localparam int RP = 6;
  localparam int RPS = 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [27:0] reqLba = '0;
  logic [15:0] reqCount = '0;
  logic [15:0] waitCycles = 16'd3;
  logic        busReq, busWe, busAck;
  logic [6:0]  busAddr;
  logic [15:0] busWdata, busRdata;
  logic        outValid, outReady;
  logic [7:0]  outByte;
  logic        done;
  logic [1:0]  errCode;

  always #5 clk = ~clk;

  cfSectorReader #(
    .COUNT_W(16), .LOCK_POLLS(LP), .READY_POLLS(RP),
    .READS_PER_SECTOR(RPS), .CFG_RESET(1), .WAIT_W(16)
  ) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqLba(reqLba), .reqCount(reqCount), .waitCycles(waitCycles),
    .busReq(busReq), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .busAck(busAck), .busRdata(busRdata), .outValid(outValid),
    .outByte(outByte), .outReady(outReady), .done(done), .errCode(errCode)
  );

  int nChecks = 0;
  int nFail = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] dataWord(input int n);
    return 16'((n * 40503 + 4660) & 16'hFFFF);
  endfunction

  // controller model
  logic [15:0] ctlReg;
  int statCount, dataIdx, accCount;
  int lockNeed, readyNeed, dropAt;
  bit cardIn, cfgBad;
  logic [15:0] loLog[16], hiLog[16], cmdLog[16];
  int nLo, nHi, nCmd;
  logic [6:0] firstAddr, secondAddr;
  logic firstWe, secondWe;
  logic [15:0] secondData;

  always @(posedge clk) begin
    if (!rstN) begin
      busAck   <= 1'b0;
      busRdata <= '0;
    end else if (busReq && busAck) begin
      busAck <= 1'b0;
      if (accCount == 0) begin firstAddr = busAddr; firstWe = busWe; end
      if (accCount == 1) begin secondAddr = busAddr; secondWe = busWe; secondData = busWdata; end
      accCount++;
      if (busWe) begin
        case (busAddr)
          7'h18: ctlReg = busWdata;
          7'h10: begin if (nLo < 16) loLog[nLo] = busWdata; nLo++; end
          7'h12: begin if (nHi < 16) hiLog[nHi] = busWdata; nHi++; end
          7'h14: begin if (nCmd < 16) cmdLog[nCmd] = busWdata; nCmd++; end
          default: ;
        endcase
      end else if (busAddr == 7'h40) begin
        if (!ctlReg[7]) cfgBad = 1'b1;
        dataIdx++;
      end
    end else if (busReq) begin
      busAck <= 1'b1;
      if (busAddr == 7'h04) begin
        logic present;
        present = cardIn && !(dropAt >= 0 && statCount >= dropAt);
        busRdata <= {7'b0, (statCount >= readyNeed), 2'b0,
                     1'($urandom_range(0, 1)), present, 2'b0,
                     (ctlReg[1] && statCount >= lockNeed), 1'b0};
        statCount++;
      end else if (busAddr == 7'h18) busRdata <= ctlReg;
      else if (busAddr == 7'h40) busRdata <= dataWord(dataIdx);
      else busRdata <= 16'h0;
    end
  end

  // stream and bus monitors
  int byteIdx;
  int streamBad;
  int badAct, badExp;
  bit holdBad, busHoldBad;
  logic prevStall; logic [7:0] prevByte;
  logic prevPend;  logic [6:0] prevAddr;
  int cycles = 0;
  bit wdFired = 0;

  always @(negedge clk) begin
    logic [15:0] w;
    logic [7:0] e;
    cycles++;
    if (rstN && prevStall && !(outValid && outByte == prevByte)) holdBad = 1'b1;
    if (rstN && prevPend && !(busReq && busAddr == prevAddr)) busHoldBad = 1'b1;
    outReady = 1'($urandom_range(0, 2) != 0);
    if (rstN && outValid && outReady) begin
      w = dataWord(byteIdx >> 1);
      e = byteIdx[0] ? w[15:8] : w[7:0];
      if (outByte != e && streamBad == 0) begin badAct = outByte; badExp = e; end
      if (outByte != e) streamBad++;
      byteIdx++;
    end
    prevStall = outValid && !outReady;
    prevByte  = outByte;
    prevPend  = busReq && !busAck;
    prevAddr  = busAddr;
  end

  task automatic prep(input logic [15:0] ctl0, input int ln, input int rn,
                      input int drop, input bit card);
    ctlReg = ctl0; lockNeed = ln; readyNeed = rn; dropAt = drop; cardIn = card;
    statCount = 0; dataIdx = 0; accCount = 0; nLo = 0; nHi = 0; nCmd = 0;
    cfgBad = 0; byteIdx = 0; streamBad = 0;
  endtask

  task automatic runReq(input logic [27:0] lba, input int count,
                        output logic [1:0] err, output int lat);
    @(negedge clk);
    reqValid = 1'b1; reqLba = lba; reqCount = 16'(count);
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    lat = 0;
    while (!done && !wdFired) begin @(negedge clk); lat++; end
    err = errCode;
    @(negedge clk);
  endtask

  task automatic checkPieces(input logic [27:0] lba, input int count);
    int rem, k, c;
    logic [27:0] l;
    rem = count; l = lba; k = 0;
    while (rem > 0 && k < 16) begin
      c = (rem > 256) ? 256 : rem;
      check(loLog[k] == l[15:0], "R5", "address low word", loLog[k], l[15:0]);
      check(hiLog[k] == {4'b0, l[27:16]}, "R5", "address high word", hiLog[k], {4'b0, l[27:16]});
      check(cmdLog[k] == (16'h0300 | 16'(c & 255)), "R6", "command word", cmdLog[k], 16'h0300 | 16'(c & 255));
      l = l + 28'(c); rem -= c; k++;
    end
    check(nCmd == k, "R10", "piece count", nCmd, k);
  endtask

  task automatic checkStream(input int count, input string req);
    check(streamBad == 0, req, "stream byte value/order", badAct, badExp);
    check(byteIdx == count * RPS * 32, "R8", "stream byte total", byteIdx, count * RPS * 32);
  endtask

  always @(negedge clk) begin
    if (cycles > 190000 && !wdFired) begin
      wdFired = 1;
      nChecks++; nFail++;
      $display("FAIL watchdog expired actual=%0d expected=<190000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [1:0] err;
    int lat;
    void'($urandom(1234));
    holdBad = 0; busHoldBad = 0; prevStall = 0; prevPend = 0;
    prep(16'h0, 0, 0, -1, 1);
    repeat (4) @(negedge clk);
    check(reqReady && !busReq && !outValid && !done, "R1", "idle state after reset",
          {reqReady, busReq, outValid, done}, 4'b1000);
    rstN = 1'b1;
    @(negedge clk);

    // R1 zero count
    prep(16'h0, 0, 0, -1, 1);
    runReq(28'h123, 0, err, lat);
    check(lat == 0, "R1", "zero-count done latency", lat, 0);
    check(err == 2'd0, "R1", "zero-count error code", err, 0);
    check(accCount == 0, "R1", "zero-count bus accesses", accCount, 0);

    // main run across a 64K boundary, 300 sectors
    prep(16'h0400, 2, 4, -1, 1);
    runReq(28'h000FF80, 300, err, lat);
    check(firstAddr == 7'h18 && !firstWe, "R2", "first access is control read", {firstWe, firstAddr}, 7'h18);
    check(secondAddr == 7'h18 && secondWe && secondData == 16'h0402, "R2", "lock set write", secondData, 16'h0402);
    checkPieces(28'h000FF80, 300);
    checkStream(300, "R9");
    check(!cfgBad, "R7", "reset bit held during data reads", cfgBad, 0);
    check(err == 2'd0, "R11", "success code", err, 0);
    check(ctlReg == 16'h0400, "R11", "control after release", ctlReg, 16'h0400);

    // 257 sectors: pieces of 256 and 1
    prep(16'h0, 0, 1, -1, 1);
    runReq(28'hABCDEF0, 257, err, lat);
    checkPieces(28'hABCDEF0, 257);
    checkStream(257, "R9");
    check(err == 2'd0 && ctlReg == 16'h0, "R7", "control cleared after 257", ctlReg, 0);

    // exactly 256
    prep(16'h0, 0, 0, -1, 1);
    runReq(28'h0000100, 256, err, lat);
    check(nCmd == 1 && cmdLog[0] == 16'h0300, "R6", "256-sector command", cmdLog[0], 16'h0300);
    checkStream(256, "R8");

    // lock timeout, card absent
    prep(16'h0, 1000, 0, -1, 0);
    runReq(28'h5, 4, err, lat);
    check(err == 2'd1, "R3", "lock timeout no-card code", err, 1);
    check(statCount == LP, "R3", "lock status polls", statCount, LP);
    check(ctlReg[1] == 1'b1, "R3", "no release after failed lock", ctlReg[1], 1);

    // lock timeout, card present
    prep(16'h0, 1000, 0, -1, 1);
    runReq(28'h5, 4, err, lat);
    check(err == 2'd2, "R3", "lock timeout locked-out code", err, 2);
    check(byteIdx == 0, "R3", "no data after lock failure", byteIdx, 0);

    // ready timeout
    prep(16'h0, 0, 1000, -1, 1);
    runReq(28'h5, 4, err, lat);
    check(err == 2'd3, "R4", "not-ready code", err, 3);
    check(statCount == 1 + RP, "R4", "ready status polls", statCount, 1 + RP);
    check(ctlReg[1] == 1'b0, "R4", "lock released after not-ready", ctlReg[1], 0);

    // card pulled during ready poll
    prep(16'h0, 0, 1000, 2, 1);
    runReq(28'h5, 4, err, lat);
    check(err == 2'd1, "R4", "card-removed code", err, 1);
    check(statCount == 3, "R4", "polls before removal seen", statCount, 3);
    check(ctlReg[1] == 1'b0 && nCmd == 0, "R4", "released, no command", {ctlReg[1], 4'(nCmd)}, 0);

    // random requests
    for (int i = 0; i < 6; i++) begin
      logic [27:0] l;
      int c;
      l = 28'($urandom);
      c = $urandom_range(1, 20);
      prep(16'(($urandom_range(0, 1)) << 12), $urandom_range(0, 2), $urandom_range(0, 5), -1, 1);
      runReq(l, c, err, lat);
      checkPieces(l, c);
      checkStream(c, "R9");
      check(err == 2'd0 && !cfgBad && ctlReg[1] == 1'b0 && ctlReg[7] == 1'b0,
            "R11", "random request end state", {err, ctlReg}, 0);
    end

    check(!holdBad, "R9", "byte held under stall", holdBad, 0);
    check(!busHoldBad, "R12", "bus access held until ack", busHoldBad, 0);

    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

endmodule